// File: doc/BRIEF.md
# Buffered SPI NOR Page Program Engine

This block drives a serial NOR flash through one chip select, one clock and one data-out line, and issues page-program transactions only. Software loads a 128-byte internal buffer through a single 32-bit data port. It sets a flash address through four byte-wide registers and then writes a command code. The engine then holds chip select low for one frame. In that frame it shifts out the page-program opcode, three address bytes and the whole buffer. A second command programs one byte taken from a byte-wide register.

The buffer is shared with a read-prefetch function, so software first switches its use to "program". The switch does not take effect at once. A configuration bit holds the request, and reading that bit back shows the state actually in force. Data-port writes and buffered program commands are refused until the switch has completed. Erase, write-enable and status polling are left to software, which drives them through other paths.

Top module: `nor_pp_engine`

## Requirements
- R1: After reset, spi_cs_n is 1 and spi_sck and spi_mosi are 0. Every readable register reads 0, the buffer holds all zeros, and the buffer is in read-prefetch use.
- R2: While a frame is in progress (busy), every register write is ignored, including address, byte, mode, data-port and command writes.
- R3: Bit 0 of the mode register (offset 0x14) requests buffer use: 0 for read prefetch, 1 for program. Reads of bit 0 return the use in force. A changed request takes effect SWITCH_LAT clock edges after the edge that writes it (4 by default), and the count only advances while the engine is not busy.
- R4: The address is held in four byte registers, loaded least significant byte first: byte 0 at 0x04, byte 1 at 0x08, byte 2 at 0x0C, and byte 3 at the separate offset 0x24. Each register reads back the value written to bits 7:0. Only bytes 2..0 are sent on the wire.
- R5: Bit 4 of the command register (offset 0x00) reads 1 from the clock edge that accepts a command until the frame ends, and reads 0 otherwise.
- R6: A frame keeps spi_cs_n low throughout and uses SPI mode 0, most significant bit first. Each bit is driven for HALF_DIV clocks with spi_sck low and then HALF_DIV clocks with spi_sck high. The frame begins with opcode 0x02, followed by address bytes 2, 1 and 0. spi_cs_n falls on the edge after the command write and rises right after the last high phase.
- R7: Data-port word k (offset 0x18) supplies buffer bytes 4k..4k+3, with bits 7:0 as byte 4k and bits 31:24 as byte 4k+3. Buffer bytes go out in ascending order.
- R8: Data-port writes are ignored unless program use is in force. The word pointer wraps after 32 words and returns to word 0 when a buffered program command is accepted. Buffer contents persist across commands.
- R9: Command code 0x10 in bits 7:0 starts a buffered frame of 128 data bytes, but only when the engine is idle and program use is in force. Otherwise it is ignored.
- R10: Command code 0x90 starts a frame whose single data byte is bits 7:0 of the byte register (offset 0x10). It is accepted when idle, whichever buffer use is in force.
- R11: Any other command code is ignored and starts no frame.
- R12: spi_mosi is 0 whenever spi_cs_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe, one write per clock |
| reg_addr | input | 8 | Register byte offset for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |

## Verification
A wrong word pointer or byte lane shows up as a misplaced byte on spi_mosi within the data phase of the next buffered frame. A wrong phase counter or bit counter shifts the spi_sck pattern or the frame length, so the pins differ from the reference within one bit time. A wrong mode-switch count changes the readback bit four edges after the request, and it changes whether the following data-port writes land. All three are caught by comparing the pins with a behavioural model on every clock.

// File: rtl/nor_pp_pkg.sv
// Shared constants for the page program engine: register offsets,
// command codes and the flash opcode. Assumes byte offsets on an 8-bit
// register address.
package nor_pp_pkg;
    localparam int REG_AW = 8;
    localparam int REG_DW = 32;

    localparam logic [REG_AW-1:0] OFS_CMD   = 8'h00;
    localparam logic [REG_AW-1:0] OFS_ADR0  = 8'h04;
    localparam logic [REG_AW-1:0] OFS_ADR1  = 8'h08;
    localparam logic [REG_AW-1:0] OFS_ADR2  = 8'h0C;
    localparam logic [REG_AW-1:0] OFS_WBYTE = 8'h10;
    localparam logic [REG_AW-1:0] OFS_MODE  = 8'h14;
    localparam logic [REG_AW-1:0] OFS_PDATA = 8'h18;
    localparam logic [REG_AW-1:0] OFS_ADR3  = 8'h24;

    localparam logic [7:0] CMD_BUF_PROG  = 8'h10;
    localparam logic [7:0] CMD_BYTE_PROG = 8'h90;
    localparam logic [7:0] FLASH_PP_OPC  = 8'h02;

    localparam int BUSY_BIT = 4;
endpackage

// File: rtl/nor_pp_regs.sv
// Register file and command decode. Holds the address bytes, the single
// data byte and the buffer-use handshake. Assumes one write per clock and
// that all writes are dropped while a frame is in progress.
module nor_pp_regs
    import nor_pp_pkg::*;
#(
    parameter int SWITCH_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              busy,
    output logic [23:0]       addr_lo,
    output logic [7:0]        wbyte,
    output logic              mode_eff,
    output logic              start_buf,
    output logic              start_single,
    output logic              push,
    output logic [REG_DW-1:0] push_word
);
    localparam int CNT_W = $clog2(SWITCH_LAT + 1);

    logic [7:0]       adr0_q, adr1_q, adr2_q, adr3_q, wbyte_q;
    logic             mode_req_q, mode_eff_q;
    logic [CNT_W-1:0] sw_cnt_q;
    logic             wr_ok;

    assign wr_ok = reg_wr && !busy;

    // Decode command and data-port writes into single-cycle strobes.
    always_comb begin
        start_buf    = wr_ok && (reg_addr == OFS_CMD)
                       && (reg_wdata[7:0] == CMD_BUF_PROG) && mode_eff_q;
        start_single = wr_ok && (reg_addr == OFS_CMD)
                       && (reg_wdata[7:0] == CMD_BYTE_PROG);
        push         = wr_ok && (reg_addr == OFS_PDATA) && mode_eff_q;
        push_word    = reg_wdata;
    end

    // Capture the byte-wide registers and the buffer-use request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adr0_q     <= '0;
            adr1_q     <= '0;
            adr2_q     <= '0;
            adr3_q     <= '0;
            wbyte_q    <= '0;
            mode_req_q <= 1'b0;
        end else if (wr_ok) begin
            case (reg_addr)
                OFS_ADR0:  adr0_q     <= reg_wdata[7:0];
                OFS_ADR1:  adr1_q     <= reg_wdata[7:0];
                OFS_ADR2:  adr2_q     <= reg_wdata[7:0];
                OFS_ADR3:  adr3_q     <= reg_wdata[7:0];
                OFS_WBYTE: wbyte_q    <= reg_wdata[7:0];
                OFS_MODE:  mode_req_q <= reg_wdata[0];
                default:   ;
            endcase
        end
    end

    // Apply a pending buffer-use change after the settle count, idle only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_eff_q <= 1'b0;
            sw_cnt_q   <= '0;
        end else if (!busy) begin
            if (mode_req_q != mode_eff_q) begin
                if (sw_cnt_q == CNT_W'(SWITCH_LAT - 1)) begin
                    mode_eff_q <= mode_req_q;
                    sw_cnt_q   <= '0;
                end else begin
                    sw_cnt_q <= sw_cnt_q + 1'b1;
                end
            end else begin
                sw_cnt_q <= '0;
            end
        end
    end

    // Return the register selected by reg_addr.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CMD:   reg_rdata[BUSY_BIT] = busy;
            OFS_ADR0:  reg_rdata[7:0] = adr0_q;
            OFS_ADR1:  reg_rdata[7:0] = adr1_q;
            OFS_ADR2:  reg_rdata[7:0] = adr2_q;
            OFS_ADR3:  reg_rdata[7:0] = adr3_q;
            OFS_WBYTE: reg_rdata[7:0] = wbyte_q;
            OFS_MODE:  reg_rdata[0]   = mode_eff_q;
            default:   reg_rdata = '0;
        endcase
    end

    assign addr_lo  = {adr2_q, adr1_q, adr0_q};
    assign wbyte    = wbyte_q;
    assign mode_eff = mode_eff_q;

    // R3: the use in force only changes while no frame is running
    a_r3_switch_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_eff_q != $past(mode_eff_q)) |-> !$past(busy));

    // R3: a change always moves toward the stored request
    a_r3_eff_takes_req: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_eff_q != $past(mode_eff_q)) |-> (mode_eff_q == $past(mode_req_q)));
endmodule

// File: rtl/nor_pp_pagebuf.sv
// Program buffer: word-wide fill from the data port, byte-wide read for the
// shifter. Assumes byte 0 of a word sits in bits 7:0.
module nor_pp_pagebuf
    import nor_pp_pkg::*;
#(
    parameter int BUF_BYTES = 128
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [REG_DW-1:0]            push_word,
    input  logic                         ptr_clr,
    input  logic [$clog2(BUF_BYTES)-1:0] rd_idx,
    output logic [7:0]                   rd_byte
);
    localparam int WORDS = BUF_BYTES / 4;
    localparam int PTR_W = $clog2(WORDS);
    localparam int IDX_W = $clog2(BUF_BYTES);

    logic [PTR_W-1:0]  wptr_q;
    logic [REG_DW-1:0] words [WORDS];
    logic [REG_DW-1:0] sel_word;

    // Advance the fill pointer per accepted word; clear it on a program start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
        end else if (ptr_clr) begin
            wptr_q <= '0;
        end else if (push) begin
            wptr_q <= wptr_q + 1'b1;
        end
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [REG_DW-1:0] word_q;
        // Store the data-port word when the pointer selects this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (push && !ptr_clr && (wptr_q == PTR_W'(w))) begin
                word_q <= push_word;
            end
        end
        assign words[w] = word_q;
    end

    // Pick the word, then the byte lane, for the shifter.
    always_comb begin
        sel_word = words[rd_idx[IDX_W-1:2]];
        rd_byte  = sel_word[8*rd_idx[1:0] +: 8];
    end

    // R8: an accepted program command restarts the fill at word 0
    a_r8_ptr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_clr |=> (wptr_q == '0));

    // R8: each accepted word moves the pointer by exactly one
    a_r8_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !ptr_clr) |=> (wptr_q == PTR_W'($past(wptr_q) + 1'b1)));
endmodule

// File: rtl/nor_pp_shifter.sv
// Serial frame sequencer: opcode, three address bytes, then either the
// buffer contents or one byte, in SPI mode 0, MSB first. Assumes the
// register file holds its values steady while busy is high.
module nor_pp_shifter
    import nor_pp_pkg::*;
#(
    parameter int HALF_DIV  = 2,
    parameter int BUF_BYTES = 128
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_buf,
    input  logic                         start_single,
    input  logic [23:0]                  addr_lo,
    input  logic [7:0]                   wbyte,
    input  logic [7:0]                   buf_byte,
    output logic [$clog2(BUF_BYTES)-1:0] buf_rd_idx,
    output logic                         busy,
    output logic                         sck,
    output logic                         mosi
);
    localparam int BIDX_W   = $clog2(BUF_BYTES + 4);
    localparam int IDX_W    = $clog2(BUF_BYTES);
    localparam int DIV_W    = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int LAST_BUF = BUF_BYTES + 3;

    logic              busy_q, single_q, sck_q;
    logic [DIV_W-1:0]  cnt_q;
    logic [2:0]        bitn_q;
    logic [BIDX_W-1:0] bidx_q, nxt_idx, last_idx;
    logic [7:0]        sr_q, next_byte;

    // Select the byte that follows the current one on the wire.
    always_comb begin
        nxt_idx    = bidx_q + 1'b1;
        last_idx   = single_q ? BIDX_W'(4) : BIDX_W'(LAST_BUF);
        buf_rd_idx = IDX_W'(nxt_idx - BIDX_W'(4));
        case (nxt_idx)
            BIDX_W'(1): next_byte = addr_lo[23:16];
            BIDX_W'(2): next_byte = addr_lo[15:8];
            BIDX_W'(3): next_byte = addr_lo[7:0];
            default:    next_byte = single_q ? wbyte : buf_byte;
        endcase
    end

    // Run the half-period timer, the bit and byte counters and the shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            single_q <= 1'b0;
            sck_q    <= 1'b0;
            cnt_q    <= '0;
            bitn_q   <= '0;
            bidx_q   <= '0;
            sr_q     <= '0;
        end else if (!busy_q) begin
            if (start_buf || start_single) begin
                busy_q   <= 1'b1;
                single_q <= start_single;
                sck_q    <= 1'b0;
                cnt_q    <= '0;
                bitn_q   <= '0;
                bidx_q   <= '0;
                sr_q     <= FLASH_PP_OPC;
            end
        end else if (cnt_q == DIV_W'(HALF_DIV - 1)) begin
            cnt_q <= '0;
            if (!sck_q) begin
                sck_q <= 1'b1;
            end else begin
                sck_q <= 1'b0;
                if (bitn_q == 3'd7) begin
                    bitn_q <= '0;
                    if (bidx_q == last_idx) begin
                        busy_q <= 1'b0;
                        sr_q   <= '0;
                    end else begin
                        bidx_q <= nxt_idx;
                        sr_q   <= next_byte;
                    end
                end else begin
                    bitn_q <= bitn_q + 1'b1;
                    sr_q   <= {sr_q[6:0], 1'b0};
                end
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign busy = busy_q;
    assign sck  = sck_q;
    assign mosi = busy_q & sr_q[7];

    // R6: every frame starts with the program opcode at byte 0
    a_r6_opcode_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> ((sr_q == FLASH_PP_OPC) && (bidx_q == '0)));

    // R6: the serial clock rests low outside a frame
    a_r6_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !sck_q);

    // R6: data does not move while the serial clock is high
    a_r6_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && sck_q && $past(sck_q) && $past(busy_q)) |-> (mosi == $past(mosi)));
endmodule

// File: rtl/nor_pp_engine.sv
// Top of the buffered page program engine: register file, program buffer
// and serial sequencer. Assumes a single attached flash device.
module nor_pp_engine
    import nor_pp_pkg::*;
#(
    parameter int BUF_BYTES  = 128,
    parameter int HALF_DIV   = 2,
    parameter int SWITCH_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi
);
    localparam int IDX_W = $clog2(BUF_BYTES);

    logic              busy, mode_eff, start_buf, start_single, push;
    logic [REG_DW-1:0] push_word;
    logic [23:0]       addr_lo;
    logic [7:0]        wbyte, buf_byte;
    logic [IDX_W-1:0]  buf_rd_idx;

    nor_pp_regs #(.SWITCH_LAT(SWITCH_LAT)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .busy         (busy),
        .addr_lo      (addr_lo),
        .wbyte        (wbyte),
        .mode_eff     (mode_eff),
        .start_buf    (start_buf),
        .start_single (start_single),
        .push         (push),
        .push_word    (push_word)
    );

    nor_pp_pagebuf #(.BUF_BYTES(BUF_BYTES)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_word (push_word),
        .ptr_clr   (start_buf),
        .rd_idx    (buf_rd_idx),
        .rd_byte   (buf_byte)
    );

    nor_pp_shifter #(.HALF_DIV(HALF_DIV), .BUF_BYTES(BUF_BYTES)) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_buf    (start_buf),
        .start_single (start_single),
        .addr_lo      (addr_lo),
        .wbyte        (wbyte),
        .buf_byte     (buf_byte),
        .buf_rd_idx   (buf_rd_idx),
        .busy         (busy),
        .sck          (spi_sck),
        .mosi         (spi_mosi)
    );

    assign spi_cs_n = !busy;

    // R9: a buffered start is never taken while the buffer is in read use
    a_r9_buf_needs_prog: assert property (@(posedge clk) disable iff (!rst_n)
        start_buf |-> mode_eff);
endmodule

// File: tb/nor_pp_engine_bench.sv
module nor_pp_engine_bench;
    import nor_pp_pkg::*;

    localparam int HALF = 2;
    localparam int LAT  = 4;
    localparam int NB   = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_cs_n, spi_sck, spi_mosi;

    int total = 0;
    int bad = 0;
    bit done = 0;

    nor_pp_engine u_nor_pp_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi)
    );

    always #2.5 clk = ~clk;

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_buf [NB];
    bit         m_bits [(NB + 4) * 8];
    int         m_nbits, m_k, m_wp, m_cnt;
    bit         m_active, m_req, m_eff;
    logic [7:0] m_a0, m_a1, m_a2, m_a3, m_wb;

    task automatic add_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_bits[m_nbits] = b[i];
            m_nbits++;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) m_buf[i] = 8'h00;
            m_active = 0; m_k = 0; m_nbits = 0; m_wp = 0;
            m_req = 0; m_eff = 0; m_cnt = 0;
            m_a0 = 0; m_a1 = 0; m_a2 = 0; m_a3 = 0; m_wb = 0;
        end else begin
            bit was_active;
            bit old_eff;
            was_active = m_active;
            old_eff = m_eff;
            if (m_active) begin
                m_k++;
                if (m_k == m_nbits * 2 * HALF) m_active = 0;
            end
            if (!was_active) begin
                if (m_req != m_eff) begin
                    if (m_cnt == LAT - 1) begin m_eff = m_req; m_cnt = 0; end
                    else m_cnt++;
                end else m_cnt = 0;
            end
            if (reg_wr && !was_active) begin
                case (reg_addr)
                    OFS_ADR0:  m_a0 = reg_wdata[7:0];
                    OFS_ADR1:  m_a1 = reg_wdata[7:0];
                    OFS_ADR2:  m_a2 = reg_wdata[7:0];
                    OFS_ADR3:  m_a3 = reg_wdata[7:0];
                    OFS_WBYTE: m_wb = reg_wdata[7:0];
                    OFS_MODE:  m_req = reg_wdata[0];
                    OFS_PDATA: if (old_eff) begin
                        for (int i = 0; i < 4; i++) m_buf[4*m_wp + i] = reg_wdata[8*i +: 8];
                        m_wp = (m_wp + 1) % (NB / 4);
                    end
                    OFS_CMD: begin
                        if ((reg_wdata[7:0] == 8'h10 && old_eff) || reg_wdata[7:0] == 8'h90) begin
                            m_nbits = 0;
                            add_byte(8'h02); add_byte(m_a2); add_byte(m_a1); add_byte(m_a0);
                            if (reg_wdata[7:0] == 8'h90) add_byte(m_wb);
                            else begin
                                for (int i = 0; i < NB; i++) add_byte(m_buf[i]);
                                m_wp = 0;
                            end
                            m_active = 1;
                            m_k = 0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Compare the pins with the model on every clock; also decode the wire.
    bit cap [(NB + 4) * 8];
    int cap_n = 0;
    bit prev_sck = 0, prev_cs = 1;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit e_cs, e_sck, e_mosi;
            e_cs = !m_active;
            e_sck = m_active && ((m_k % (2 * HALF)) >= HALF);
            e_mosi = m_active && m_bits[m_k / (2 * HALF)];
            total++;
            if (spi_cs_n !== e_cs || spi_sck !== e_sck || spi_mosi !== e_mosi) begin
                bad++;
                $display("FAIL R6 R7 R8 R9 R10 R12 pins cs/sck/mosi actual=%b%b%b expected=%b%b%b at %0t",
                         spi_cs_n, spi_sck, spi_mosi, e_cs, e_sck, e_mosi, $time);
            end
            if (prev_cs && !spi_cs_n) cap_n = 0;
            if (spi_sck && !prev_sck) begin cap[cap_n] = spi_mosi; cap_n++; end
            prev_sck = spi_sck;
            prev_cs = spi_cs_n;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle();
        while (spi_cs_n == 1'b0) @(negedge clk);
    endtask

    function automatic logic [7:0] cap_byte(input int i);
        logic [7:0] b;
        for (int j = 0; j < 8; j++) b[7-j] = cap[8*i + j];
        return b;
    endfunction

    function automatic logic [31:0] pat(input int k, input logic [31:0] x);
        return {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)} ^ x;
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- test sequence ----------------
    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 cs_n", {31'b0, spi_cs_n}, 32'd1);
        check("R1 sck", {31'b0, spi_sck}, 32'd0);
        check("R1 mosi", {31'b0, spi_mosi}, 32'd0);
        peek(OFS_CMD, v);  check("R1 cmd", v, 32'd0);
        peek(OFS_MODE, v); check("R1 mode", v, 32'd0);
        peek(OFS_ADR3, v); check("R1 adr3", v, 32'd0);

        // R8: data port writes in read use are dropped (buffer stays zero)
        wr(OFS_PDATA, 32'hDEAD_BEEF);
        wr(OFS_PDATA, 32'h1234_5678);

        // R4: address bytes, byte 3 at its own offset
        wr(OFS_ADR0, 32'hC3); wr(OFS_ADR1, 32'hB2); wr(OFS_ADR2, 32'hA1);
        wr(OFS_ADR3, 32'h5E); wr(OFS_WBYTE, 32'h3C);

        // R10: single-byte program in read use
        wr(OFS_CMD, 32'h90);
        peek(OFS_CMD, v); check("R5 busy after accept", v, 32'h10);
        wr(OFS_ADR0, 32'hFF);          // R2: dropped while busy
        wr(OFS_CMD, 32'h90);           // R2: no restart while busy
        wait_idle();
        peek(OFS_CMD, v); check("R5 busy clear", v, 32'd0);
        check("R10 bits captured", cap_n, 32'd40);
        check("R10 data byte", {24'b0, cap_byte(4)}, 32'h3C);
        peek(OFS_ADR0, v); check("R2 adr0 kept", v, 32'hC3);
        peek(OFS_ADR1, v); check("R4 adr1", v, 32'hB2);
        peek(OFS_ADR2, v); check("R4 adr2", v, 32'hA1);
        peek(OFS_ADR3, v); check("R4 adr3", v, 32'h5E);
        check("R6 opcode byte", {24'b0, cap_byte(0)}, 32'h02);
        check("R4 addr msb first", {24'b0, cap_byte(1)}, 32'hA1);

        // R11: unknown code ignored
        wr(OFS_CMD, 32'h55);
        check("R11 no frame", {31'b0, spi_cs_n}, 32'd1);
        // R9: buffered program refused in read use
        wr(OFS_CMD, 32'h10);
        check("R9 refused in read use", {31'b0, spi_cs_n}, 32'd1);

        // R3: switch to program use, settle timing
        wr(OFS_MODE, 32'h1);
        for (int i = 0; i <= LAT; i++) begin
            if (i > 0) @(negedge clk);
            peek(OFS_MODE, v);
            check("R3 mode readback", v, (i == LAT) ? 32'd1 : 32'd0);
        end

        // R7: full buffer fill and buffered program
        for (int k = 0; k < NB / 4; k++) wr(OFS_PDATA, pat(k, 32'h5AC3_961E));
        wr(OFS_CMD, 32'h10);
        peek(OFS_CMD, v); check("R5 busy buffered", v, 32'h10);
        wr(OFS_MODE, 32'h0);           // R2: dropped while busy
        wait_idle();
        check("R9 bits captured", cap_n, (NB + 4) * 8);
        check("R7 low lane first", {24'b0, cap_byte(4)}, {24'b0, pat(0, 32'h5AC3_961E)[7:0]});
        check("R7 high lane", {24'b0, cap_byte(7)}, {24'b0, pat(0, 32'h5AC3_961E)[31:24]});
        check("R7 last byte", {24'b0, cap_byte(NB + 3)}, {24'b0, pat(NB/4 - 1, 32'h5AC3_961E)[31:24]});
        repeat (LAT + 2) @(negedge clk);
        peek(OFS_MODE, v); check("R2 mode write dropped", v, 32'd1);

        // R8: pointer reset after command, partial refill keeps old tail
        for (int k = 0; k < 2; k++) wr(OFS_PDATA, pat(k, 32'h0F0F_F0F0));
        wr(OFS_CMD, 32'h10);
        wait_idle();
        check("R8 new word 1", {24'b0, cap_byte(4 + 4)}, {24'b0, pat(1, 32'h0F0F_F0F0)[7:0]});
        check("R8 old word 2", {24'b0, cap_byte(4 + 8)}, {24'b0, pat(2, 32'h5AC3_961E)[7:0]});

        // R8: wrap after 32 words
        for (int k = 0; k < NB / 4 + 1; k++) wr(OFS_PDATA, pat(k, 32'h3333_CCCC));
        wr(OFS_CMD, 32'h10);
        wait_idle();
        check("R8 wrap overwrote word 0", {24'b0, cap_byte(4)}, {24'b0, pat(NB/4, 32'h3333_CCCC)[7:0]});
        check("R12 mosi idle", {31'b0, spi_mosi}, 32'd0);

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule